// File: doc/BRIEF.md
# Byte FIFO with Watermark Alerts and Interrupt Requests

This block is a 64-entry, 8-bit first-in first-out store. A host register port and an internal engine share it. A push stores a byte at the write position. A pop returns the oldest byte on the following cycle. A flush discards everything that is stored.

A control state machine tracks the fill condition in three states: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. Its transitions are:

- `T_FIRST_PUSH` moves from `ST_EMPTY` to `ST_PARTIAL`.
- `T_LAST_POP` moves from `ST_PARTIAL` to `ST_EMPTY`.
- `T_FILL_UP` moves from `ST_PARTIAL` to `ST_FULL`.
- `T_DRAIN_ONE` moves from `ST_FULL` to `ST_PARTIAL`.
- `T_FLUSH` moves from any state to `ST_EMPTY`.

The state machine decides which requests reach the storage, and it keeps the fill count and a sticky overflow flag.

A programmable 6-bit water level drives two alerts:

- The high alert warns that little free room remains.
- The low alert warns that few bytes remain stored.

Each alert that turns on latches a request bit. The host clears a request bit by writing a one to it. A request bit whose enable is set drives the interrupt output.

Top module: `byte_fifo_alert`

## Requirements
- R1: After reset, the FIFO is as follows: `length_o` is 0, `ovfl_o` is 0, both request bits are 0, `irq_o` is 0, `pop_data_o` is 0, the water level is 8 and both enables are 0. With these values, `lo_alert_o` is 1 and `hi_alert_o` is 0.
- R2: Popped bytes come out in the order they were pushed. A byte popped at a clock edge appears on `pop_data_o` after that edge and holds until the next successful pop.
- R3: `length_o` is the number of stored bytes, from 0 to 64. A push and a pop in the same cycle, while neither empty nor full, leave it unchanged.
- R4: A push while full is dropped, and the stored bytes and their order are kept. It sets `ovfl_o`. `ovfl_o` then stays at 1 until a flush.
- R5: A pop while empty leaves `pop_data_o` and `length_o` unchanged and sets no flag.
- R6: A flush sets `length_o` to 0 and clears `ovfl_o` after the edge, and the discarded bytes are never popped. A push or pop in the same cycle as a flush is ignored.
- R7: `hi_alert_o` is 1 exactly when (64 − `length_o`) ≤ water level.
- R8: `lo_alert_o` is 1 exactly when `length_o` ≤ water level.
- R9: At the edge where an alert is 1 but was 0 on the previous cycle, its request bit is set. The request is visible one cycle after the alert rises. Bit 1 of `irq_req_o` belongs to the high alert and bit 0 to the low alert. The alert values present at reset raise no request. A set beats a clear in the same cycle.
- R10: Writing a 1 on a bit of `irq_clr_i` clears that request bit at the next edge. A 0 on a bit of `irq_clr_i` leaves that request bit unchanged.
- R11: `irq_o` is 1 exactly when some request bit is 1 and its enable bit is 1. `irq_en_we_i` loads the enables from `irq_en_i`, with bit 1 for the high alert and bit 0 for the low alert.
- R12: `level_we_i` loads the 6-bit water level from `level_i`. The alerts use the new level from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Store `push_data_i` |
| push_data_i | input | 8 | Byte to store |
| pop_i | input | 1 | Remove the oldest byte |
| pop_data_o | output | 8 | Last popped byte |
| flush_i | input | 1 | Discard all contents and clear overflow |
| level_we_i | input | 1 | Load the water level |
| level_i | input | 6 | New water level |
| irq_en_we_i | input | 1 | Load the interrupt enables |
| irq_en_i | input | 2 | New enables, bit 1 high alert, bit 0 low alert |
| irq_clr_i | input | 2 | Write-1-to-clear for the request bits |
| length_o | output | 7 | Number of stored bytes |
| hi_alert_o | output | 1 | Free room at or below the water level |
| lo_alert_o | output | 1 | Fill at or below the water level |
| ovfl_o | output | 1 | Sticky flag for a push while full |
| irq_req_o | output | 2 | Latched requests, bit 1 high, bit 0 low |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions assume that every control input is a clean level sampled at the clock edge. They also assume that a request arriving in the same cycle as a flush is meant to be discarded. The length-step property relies on no more than one push and one pop being possible per cycle, and the port widths guarantee this. The stimulus drives the inputs only between edges, on the falling edge. It then mixes the following:

- directed runs to full, to empty and past both;
- flushes with and without concurrent requests;
- level changes to both extremes;
- long pseudo-random traffic.

// File: rtl/fifo_alert_pkg.sv
package fifo_alert_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;

    localparam int IRQ_LO_BIT = 0;
    localparam int IRQ_HI_BIT = 1;
    localparam int IRQ_NUM    = 2;

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr_q;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [DATA_W-1:0] rd_data_q;

    // Storage array: written only, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr_q] <= wr_data;
        end
    end

    // Pointers wrap naturally because the depth is a power of two.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q  <= '0;
            rd_ptr_q  <= '0;
            rd_data_q <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
            if (rd_en) begin
                rd_ptr_q  <= rd_ptr_q + 1'b1;
                rd_data_q <= mem[rd_ptr_q];
            end
        end
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/fifo_fill_ctrl.sv
module fifo_fill_ctrl
    import fifo_alert_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic             wr_en,
    output logic             rd_en,
    output logic [CNT_W-1:0] count,
    output logic             ovfl
);
    localparam logic [CNT_W-1:0] DEPTH_C     = CNT_W'(1 << ADDR_W);
    localparam logic [CNT_W-1:0] LAST_FREE_C = DEPTH_C - 1'b1;

    fill_state_e      state_q, state_nxt;
    logic [CNT_W-1:0] count_q;
    logic             ovfl_q;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transition process: T_FLUSH, T_FIRST_PUSH, T_LAST_POP, T_FILL_UP, T_DRAIN_ONE.
    always_comb begin
        state_nxt = state_q;
        if (flush) begin
            state_nxt = ST_EMPTY;                         // T_FLUSH
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (wr_en) state_nxt = ST_PARTIAL;    // T_FIRST_PUSH
                end
                ST_PARTIAL: begin
                    if (wr_en && !rd_en && count_q == LAST_FREE_C)
                        state_nxt = ST_FULL;              // T_FILL_UP
                    else if (rd_en && !wr_en && count_q == CNT_W'(1))
                        state_nxt = ST_EMPTY;             // T_LAST_POP
                end
                ST_FULL: begin
                    if (rd_en) state_nxt = ST_PARTIAL;    // T_DRAIN_ONE
                end
                default: state_nxt = ST_EMPTY;
            endcase
        end
    end

    // Output process: which requests reach the storage in each state.
    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                wr_en = push && !flush;
            end
            ST_PARTIAL: begin
                wr_en = push && !flush;
                rd_en = pop && !flush;
            end
            ST_FULL: begin
                rd_en = pop && !flush;
            end
            default: begin
                wr_en = 1'b0;
                rd_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            ovfl_q  <= 1'b0;
        end else if (flush) begin
            count_q <= '0;
            ovfl_q  <= 1'b0;
        end else begin
            count_q <= count_q + CNT_W'(wr_en) - CNT_W'(rd_en);
            if (push && state_q == ST_FULL) begin
                ovfl_q <= 1'b1;
            end
        end
    end

    assign count = count_q;
    assign ovfl  = ovfl_q;

endmodule

// File: rtl/alert_irq.sv
module alert_irq
    import fifo_alert_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int LEVEL_RST = 8,
    localparam int CNT_W    = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count,
    input  logic               level_we,
    input  logic [ADDR_W-1:0]  level_wdata,
    input  logic               en_we,
    input  logic [IRQ_NUM-1:0] en_wdata,
    input  logic [IRQ_NUM-1:0] clr,
    output logic               hi_alert,
    output logic               lo_alert,
    output logic [IRQ_NUM-1:0] req,
    output logic               irq
);
    localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(1 << ADDR_W);
    localparam logic [CNT_W-1:0] LVL_RST_C = CNT_W'(LEVEL_RST);
    // Alert values present right after reset (fill is zero).
    localparam logic HI_AT_RST = (DEPTH_C <= LVL_RST_C);
    localparam logic LO_AT_RST = 1'b1;

    logic [ADDR_W-1:0]  level_q;
    logic [IRQ_NUM-1:0] en_q;
    logic [IRQ_NUM-1:0] req_q;
    logic [IRQ_NUM-1:0] prev_q;
    logic [IRQ_NUM-1:0] alert_vec;
    logic [CNT_W-1:0]   free_room;

    assign free_room = DEPTH_C - count;
    assign hi_alert  = free_room <= CNT_W'(level_q);
    assign lo_alert  = count <= CNT_W'(level_q);

    always_comb begin
        alert_vec             = '0;
        alert_vec[IRQ_HI_BIT] = hi_alert;
        alert_vec[IRQ_LO_BIT] = lo_alert;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= ADDR_W'(LEVEL_RST);
            en_q    <= '0;
        end else begin
            if (level_we) level_q <= level_wdata;
            if (en_we)    en_q    <= en_wdata;
        end
    end

    // One edge detector and request latch per alert source.
    for (genvar g = 0; g < IRQ_NUM; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= (g == IRQ_HI_BIT) ? HI_AT_RST : LO_AT_RST;
                req_q[g]  <= 1'b0;
            end else begin
                prev_q[g] <= alert_vec[g];
                if (alert_vec[g] && !prev_q[g]) begin
                    req_q[g] <= 1'b1;
                end else if (clr[g]) begin
                    req_q[g] <= 1'b0;
                end
            end
        end
    end

    assign req = req_q;
    assign irq = |(req_q & en_q);

endmodule

// File: rtl/byte_fifo_alert.sv
module byte_fifo_alert #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 6,
    parameter int LEVEL_RST = 8,
    localparam int CNT_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    input  logic              flush_i,
    input  logic              level_we_i,
    input  logic [ADDR_W-1:0] level_i,
    input  logic              irq_en_we_i,
    input  logic [1:0]        irq_en_i,
    input  logic [1:0]        irq_clr_i,
    output logic [CNT_W-1:0]  length_o,
    output logic              hi_alert_o,
    output logic              lo_alert_o,
    output logic              ovfl_o,
    output logic [1:0]        irq_req_o,
    output logic              irq_o
);
    logic wr_en;
    logic rd_en;

    fifo_fill_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_i),
        .pop   (pop_i),
        .flush (flush_i),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .count (length_o),
        .ovfl  (ovfl_o)
    );

    fifo_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_i),
        .wr_en   (wr_en),
        .wr_data (push_data_i),
        .rd_en   (rd_en),
        .rd_data (pop_data_o)
    );

    alert_irq #(
        .ADDR_W    (ADDR_W),
        .LEVEL_RST (LEVEL_RST)
    ) u_alert (
        .clk         (clk),
        .rst_n       (rst_n),
        .count       (length_o),
        .level_we    (level_we_i),
        .level_wdata (level_i),
        .en_we       (irq_en_we_i),
        .en_wdata    (irq_en_i),
        .clr         (irq_clr_i),
        .hi_alert    (hi_alert_o),
        .lo_alert    (lo_alert_o),
        .req         (irq_req_o),
        .irq         (irq_o)
    );

endmodule

// File: rtl/fifo_alert_chk.sv
module fifo_alert_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7,
    parameter int DEPTH  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic              flush_i,
    input logic [CNT_W-1:0]  length_o,
    input logic              hi_alert_o,
    input logic              lo_alert_o,
    input logic              ovfl_o,
    input logic [DATA_W-1:0] pop_data_o,
    input logic [1:0]        irq_req_o
);
    AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        length_o <= CNT_W'(DEPTH)); // R3

    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> (length_o == $past(length_o) || length_o == $past(length_o) + 1'b1
                      || length_o + 1'b1 == $past(length_o))); // R3

    AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl_o && !flush_i |=> ovfl_o); // R4

    AST_OVFL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !flush_i && length_o == CNT_W'(DEPTH) |=> ovfl_o); // R4

    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !push_i && !flush_i && length_o == '0 |=> $stable(pop_data_o) && length_o == '0); // R5

    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> length_o == '0 && !ovfl_o); // R6

    AST_HI_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_alert_o) |=> irq_req_o[1]); // R9

    AST_LO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_alert_o) |=> irq_req_o[0]); // R9

endmodule

bind byte_fifo_alert fifo_alert_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .DEPTH  (1 << ADDR_W)
) u_chk (.*);

// File: tb/test_byte_fifo_alert.sv
module test_byte_fifo_alert;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       pop_i = 1'b0;
    logic [7:0] pop_data_o;
    logic       flush_i = 1'b0;
    logic       level_we_i = 1'b0;
    logic [5:0] level_i = '0;
    logic       irq_en_we_i = 1'b0;
    logic [1:0] irq_en_i = '0;
    logic [1:0] irq_clr_i = '0;
    logic [6:0] length_o;
    logic       hi_alert_o, lo_alert_o, ovfl_o, irq_o;
    logic [1:0] irq_req_o;

    always #5 clk = ~clk;

    byte_fifo_alert i_byte_fifo_alert (.*);

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural reference model.
    byte unsigned q[$];
    int   m_lvl, m_pdata, m_ovfl;
    bit [1:0] m_req, m_en, m_prev;

    function automatic bit m_hi();
        return (64 - q.size()) <= m_lvl;
    endfunction
    function automatic bit m_lo();
        return q.size() <= m_lvl;
    endfunction

    task automatic model_reset();
        q.delete();
        m_lvl = 8; m_pdata = 0; m_ovfl = 0;
        m_req = 2'b00; m_en = 2'b00; m_prev = 2'b01;
    endtask

    task automatic model_step();
        bit [1:0] now;
        bit was_full, was_empty;
        now = {m_hi(), m_lo()};
        m_req = (m_req & ~irq_clr_i) | (now & ~m_prev);
        m_prev = now;
        if (flush_i) begin
            q.delete();
            m_ovfl = 0;
        end else begin
            was_full = q.size() == 64;
            was_empty = q.size() == 0;
            if (pop_i && !was_empty) m_pdata = q.pop_front();
            if (push_i) begin
                if (was_full) m_ovfl = 1;
                else q.push_back(push_data_i);
            end
        end
        if (level_we_i) m_lvl = level_i;
        if (irq_en_we_i) m_en = irq_en_i;
    endtask

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        check("R3 length", length_o, q.size());
        check("R2 pop data", pop_data_o, m_pdata);
        check("R4 overflow", ovfl_o, m_ovfl);
        check("R7 high alert", hi_alert_o, m_hi());
        check("R8 low alert", lo_alert_o, m_lo());
        check("R9 R10 requests", irq_req_o, m_req);
        check("R11 irq", irq_o, |(m_req & m_en));
    endtask

    task automatic idle_inputs();
        push_i = 0; pop_i = 0; flush_i = 0; level_we_i = 0;
        irq_en_we_i = 0; irq_clr_i = 2'b00;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic push_n(int n, int base);
        for (int i = 0; i < n; i++) begin
            push_i = 1; push_data_i = 8'(base + i * 7);
            tick();
        end
    endtask

    task automatic pop_n(int n);
        for (int i = 0; i < n; i++) begin
            pop_i = 1;
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values
        compare();
        check("R1 length zero", length_o, 0);
        check("R1 low alert", lo_alert_o, 1);
        rst_n = 1;
        tick(); tick();
        check("R1 no request from reset", irq_req_o, 0);

        // R2 ordering, R12 default level, R8 low alert edge
        push_n(10, 16);
        pop_n(10);
        check("R2 last popped byte", pop_data_o, 8'(16 + 9 * 7));
        // R5 pop when empty
        pop_n(3);
        check("R5 empty pop keeps data", pop_data_o, 8'(16 + 9 * 7));

        // R11 enable and R10 clear
        irq_en_we_i = 1; irq_en_i = 2'b11; tick();
        irq_clr_i = 2'b11; tick();
        check("R10 cleared", irq_req_o, 0);

        // Fill to full and beyond: R4, R7
        push_n(64, 3);
        check("R3 full length", length_o, 64);
        check("R7 high alert when full", hi_alert_o, 1);
        push_n(3, 200);
        check("R4 overflow set", ovfl_o, 1);
        // Full with push and pop at once: pop only
        push_i = 1; push_data_i = 8'hEE; pop_i = 1; tick();
        check("R4 push on full dropped", length_o, 63);
        // R3 simultaneous push/pop while partial
        push_i = 1; push_data_i = 8'h11; pop_i = 1; tick();
        check("R3 length unchanged", length_o, 63);
        pop_n(20);
        check("R4 overflow still set", ovfl_o, 1);

        // R12 level extremes
        level_we_i = 1; level_i = 6'd63; tick();
        level_we_i = 1; level_i = 6'd0; tick();
        level_we_i = 1; level_i = 6'd43; tick();

        // R6 flush with concurrent push and pop
        flush_i = 1; push_i = 1; pop_i = 1; push_data_i = 8'h77; tick();
        check("R6 flush length", length_o, 0);
        check("R6 flush overflow", ovfl_o, 0);
        push_n(2, 90);
        pop_n(3);
        check("R6 discarded data gone", pop_data_o, 8'(90 + 7));

        // R9 set beats clear: raise low alert while clearing
        level_we_i = 1; level_i = 6'd0; tick();
        irq_clr_i = 2'b11; push_i = 1; push_data_i = 8'h5; tick();
        pop_i = 1; irq_clr_i = 2'b11; tick();
        irq_clr_i = 2'b11; tick();

        // Pseudo-random traffic
        level_we_i = 1; level_i = 6'd8; tick();
        for (int c = 0; c < 6000; c++) begin
            int bias;
            bias = ((c / 400) % 2 == 0) ? 70 : 30;
            push_i = ($urandom_range(99) < bias);
            pop_i = ($urandom_range(99) < 100 - bias);
            push_data_i = 8'($urandom_range(255));
            flush_i = ($urandom_range(999) < 3);
            level_we_i = ($urandom_range(99) < 2);
            level_i = 6'($urandom_range(63));
            irq_en_we_i = ($urandom_range(99) < 3);
            irq_en_i = 2'($urandom_range(3));
            irq_clr_i = ($urandom_range(99) < 10) ? 2'($urandom_range(3)) : 2'b00;
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule